// File: doc/BRIEF.md
# Packet-Boundary Receive Byte Buffer

This block sits between an HDLC-style frame receiver and a host processor. The receiver hands it one byte at a time, together with a marker on the final byte of each frame and that frame's completion status (good, aborted or CRC error). The block keeps up to 64 bytes in a first-in first-out store. Each stored byte carries its end marker and its status, so frame edges are not lost inside the buffer.

The host sees a byte-count register whose low seven bits say how many bytes it may read next. That count never crosses a frame edge. The top bit is set when the counted bytes do not finish a frame, meaning they are the opening part or a middle part of it. In that case the host has no status to check. When the top bit is clear, the counted bytes close a frame, which may be a tail or a whole frame. After the host pops the last of them, the frame's status appears in a readable register and a latched completion event is raised.

A write that arrives when the buffer is full is discarded and raises a latched overrun event. Each event stays set until the host pulses its clear input.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset the buffer is empty, `bytes_avail` is 8'h80, `host_byte` is 0, `pkt_status` is 0, and both events are 0.
- R2: When the buffer holds fewer than 64 bytes, an `in_valid` byte is stored. The host reads bytes back in arrival order. A byte popped by `host_rd` appears on `host_byte` after the same clock edge.
- R3: When the buffer holds 64 bytes, an `in_valid` byte is dropped even if `host_rd` is high in the same cycle. The drop sets `overrun` at that edge and leaves the stored contents and count unchanged.
- R4: When any stored byte carries the end marker, `bytes_avail[6:0]` equals the number of bytes from the head up to and including the first marked byte, and `bytes_avail[7]` is 0.
- R5: When no stored byte carries the end marker, `bytes_avail[6:0]` equals the number of stored bytes and `bytes_avail[7]` is 1. An empty buffer therefore reports 8'h80.
- R6: `bytes_avail` is registered. It shows the buffer state that held before the previous clock edge, so it lags a push or pop by one cycle.
- R7: Popping a marked byte loads that byte's status into `pkt_status` and sets `pkt_done` at the same edge. Status codes are 0 = good, 1 = aborted, 2 = CRC error. Popping an unmarked byte leaves both unchanged.
- R8: `host_rd` on an empty buffer is ignored: `host_byte`, `bytes_avail` and the events keep their values.
- R9: `pkt_done` and `overrun` stay set until their clear inputs are high at a clock edge. If a new event and its clear occur in the same cycle, the event wins.
- R10: A full buffer with no marker reports 8'hC0 (count 64 with the top bit set). A full buffer whose 64th byte is the first marked byte reports 8'h40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receiver byte strobe |
| in_byte | input | 8 | Received byte |
| in_last | input | 1 | Byte is the final byte of its frame |
| in_status | input | 2 | Frame status, sampled with the final byte |
| host_rd | input | 1 | Host pop request, one byte per cycle |
| clr_pkt_done | input | 1 | Clear pulse for the completion event |
| clr_overrun | input | 1 | Clear pulse for the overrun event |
| host_byte | output | 8 | Most recently popped byte |
| bytes_avail | output | 8 | [7] chunk does not end a frame, [6:0] safe byte count |
| pkt_status | output | 2 | Status of the last frame whose final byte was popped |
| pkt_done | output | 1 | Latched frame-completion event |
| overrun | output | 1 | Latched drop-on-full event |

## Verification
The hardest case to reach from the ports is the full buffer. There the count reaches 64, which fills the seven-bit field, and a dropped write must leave both the contents and the count unchanged. The bench reaches this case by sweeping every frame length from 1 to 64. Each frame is first pushed without its marker, then completed, and the count is checked at both points. A separate run fills the buffer with 64 unmarked bytes, pushes one more, and then drains all 64 bytes to confirm that nothing was overwritten.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    RXST_GOOD  = 2'd0,
    RXST_ABORT = 2'd1,
    RXST_CRC   = 2'd2
  } rx_status_e;

  localparam int RXF_STW = 2;
endpackage

// File: rtl/rxf_store.sv
// Byte store with per-entry end tag and status, pointers and fill level.
module rxf_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int STW   = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_byte,
  input  logic             in_last,
  input  logic [STW-1:0]   in_status,
  input  logic             host_rd,
  output logic [DW-1:0]    rd_byte,
  output logic [CW-1:0]    level,
  output logic [AW-1:0]    head,
  output logic [DEPTH-1:0] last_tags,
  output logic             pop_last,
  output logic [STW-1:0]   pop_status,
  output logic             drop
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [DW-1:0]    mem  [DEPTH];
  logic [STW-1:0]   st_q [DEPTH];
  logic [DEPTH-1:0] tag_q;
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    lvl_q;
  logic [DW-1:0]    rd_q;
  logic             wr_ok, rd_ok;

  assign wr_ok = in_valid && (lvl_q != FULL_LVL);
  assign rd_ok = host_rd && (lvl_q != '0);
  assign drop  = in_valid && (lvl_q == FULL_LVL);

  // Data array: synchronous write, registered read (RAM friendly).
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_ok) rd_q <= mem[rptr];
  end

  // Status per entry, read combinationally at the head.
  always_ff @(posedge clk) begin
    if (wr_ok) st_q[wptr] <= in_status;
  end

  // End tags kept in flops so the whole window is visible at once.
  always_ff @(posedge clk) begin
    if (rst)        tag_q <= '0;
    else if (wr_ok) tag_q[wptr] <= in_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      lvl_q <= lvl_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  assign rd_byte    = rd_q;
  assign level      = lvl_q;
  assign head       = rptr;
  assign last_tags  = tag_q;
  assign pop_last   = rd_ok && tag_q[rptr];
  assign pop_status = st_q[rptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= FULL_LVL); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lvl_q == FULL_LVL && !host_rd) |=> lvl_q == FULL_LVL); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (host_rd && lvl_q == '0 && !in_valid) |=> ($stable(rd_q) && lvl_q == '0)); // R8
endmodule

// File: rtl/rxf_boundary_scan.sv
// Counts bytes from the head to the first end tag, or all stored bytes.
module rxf_boundary_scan #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic [DEPTH-1:0] last_tags,
  input  logic [AW-1:0]    head,
  input  logic [CW-1:0]    level,
  output logic [CW-1:0]    chunk,
  output logic             ends
);
  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_win
    localparam logic [AW-1:0] OFS = AW'(g);
    localparam logic [CW-1:0] POS = CW'(g);
    logic [AW-1:0] idx;
    assign idx    = head + OFS;
    assign hit[g] = last_tags[idx] && (POS < level);
  end

  always_comb begin
    ends  = 1'b0;
    chunk = level;
    for (int i = 0; i < DEPTH; i++) begin
      if (!ends && hit[i]) begin
        ends  = 1'b1;
        chunk = CW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/rxf_events.sv
// Frame status register and latched events with clear-on-pulse.
module rxf_events #(
  parameter int STW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pop_last,
  input  logic [STW-1:0] pop_status,
  input  logic           drop,
  input  logic           clr_pkt_done,
  input  logic           clr_overrun,
  output logic [STW-1:0] pkt_status,
  output logic           pkt_done,
  output logic           overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_status <= '0;
      pkt_done   <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (pop_last)          pkt_status <= pop_status;
      if (pop_last)          pkt_done   <= 1'b1;
      else if (clr_pkt_done) pkt_done   <= 1'b0;
      if (drop)              overrun    <= 1'b1;
      else if (clr_overrun)  overrun    <= 1'b0;
    end
  end

  AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
    pop_last |=> pkt_done); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && !clr_pkt_done) |=> pkt_done); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    drop |=> overrun); // R3
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clr_overrun) |=> overrun); // R9
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int STW   = rxf_pkg::RXF_STW,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int AVW  = CW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_byte,
  input  logic           in_last,
  input  logic [STW-1:0] in_status,
  input  logic           host_rd,
  input  logic           clr_pkt_done,
  input  logic           clr_overrun,
  output logic [DW-1:0]  host_byte,
  output logic [AVW-1:0] bytes_avail,
  output logic [STW-1:0] pkt_status,
  output logic           pkt_done,
  output logic           overrun
);
  logic [CW-1:0]    level, chunk;
  logic [AW-1:0]    head;
  logic [DEPTH-1:0] last_tags;
  logic             pop_last, drop, ends;
  logic [STW-1:0]   pop_status;
  logic [AVW-1:0]   avail_q;

  rxf_store #(.DEPTH(DEPTH), .DW(DW), .STW(STW)) store_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last), .in_status(in_status),
    .host_rd(host_rd), .rd_byte(host_byte), .level(level), .head(head),
    .last_tags(last_tags), .pop_last(pop_last), .pop_status(pop_status), .drop(drop)
  );

  rxf_boundary_scan #(.DEPTH(DEPTH)) scan_i (
    .last_tags(last_tags), .head(head), .level(level), .chunk(chunk), .ends(ends)
  );

  rxf_events #(.STW(STW)) evt_i (
    .clk(clk), .rst(rst), .pop_last(pop_last), .pop_status(pop_status), .drop(drop),
    .clr_pkt_done(clr_pkt_done), .clr_overrun(clr_overrun),
    .pkt_status(pkt_status), .pkt_done(pkt_done), .overrun(overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) avail_q <= {1'b1, {CW{1'b0}}};
    else     avail_q <= {~ends, chunk};
  end

  assign bytes_avail = avail_q;

  AST_END_NONZERO: assert property (@(posedge clk) disable iff (rst)
    !avail_q[AVW-1] |-> avail_q[CW-1:0] != '0); // R4
  AST_AVAIL_BOUND: assert property (@(posedge clk) disable iff (rst)
    avail_q[CW-1:0] <= $past(level)); // R6
endmodule

// File: tb/rx_pkt_fifo_tb_top.sv
module rx_pkt_fifo_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, host_rd = 1'b0;
  logic clr_pkt_done = 1'b0, clr_overrun = 1'b0;
  logic [7:0] in_byte = '0;
  logic [1:0] in_status = '0;
  logic [7:0] host_byte, bytes_avail;
  logic [1:0] pkt_status;
  logic pkt_done, overrun;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  rx_pkt_fifo dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
    .in_status(in_status), .host_rd(host_rd), .clr_pkt_done(clr_pkt_done),
    .clr_overrun(clr_overrun), .host_byte(host_byte), .bytes_avail(bytes_avail),
    .pkt_status(pkt_status), .pkt_done(pkt_done), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic last, input logic [1:0] st);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_last = last; in_status = st;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic clear_done();
    @(negedge clk);
    clr_pkt_done = 1'b1;
    @(negedge clk);
    clr_pkt_done = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int l, input int i);
    return 8'((l * 37 + i * 11) & 8'hFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 avail", bytes_avail, 8'h80);
    chk("R1 host_byte", host_byte, 0);
    chk("R1 status", pkt_status, 0);
    chk("R1 done", pkt_done, 0);
    chk("R1 overrun", overrun, 0);

    // R6 latency: one byte pushed, count appears one cycle later
    push(8'h5A, 1'b0, 2'd0);
    chk("R6 before", bytes_avail, 8'h80);
    idle();
    chk("R6 after", bytes_avail, 8'h81);
    pop();
    chk("R2 single", host_byte, 8'h5A);
    idle();
    chk("R5 empty", bytes_avail, 8'h80);

    // Sweep every frame length 1..64
    for (int l = 1; l <= 64; l++) begin
      for (int i = 0; i < l - 1; i++) push(pat(l, i), 1'b0, 2'd0);
      idle();
      if (l > 1) chk("R5 partial", bytes_avail, 8'h80 | (l - 1));
      push(pat(l, l - 1), 1'b1, 2'(l % 3));
      idle();
      if (l == 64) chk("R10 full marked", bytes_avail, 8'h40);
      else         chk("R4 whole", bytes_avail, l);
      for (int i = 0; i < l; i++) begin
        pop();
        chk("R2 order", host_byte, pat(l, i));
        if (i == 0 && l > 1) chk("R7 no early done", pkt_done, 0);
      end
      chk("R7 status", pkt_status, l % 3);
      chk("R7 done", pkt_done, 1);
      idle();
      chk("R5 drained", bytes_avail, 8'h80);
      clear_done();
      chk("R9 cleared", pkt_done, 0);
    end

    // Two frames queued: count stops at the first boundary
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i), i == 2, 2'd1);
    for (int i = 0; i < 5; i++) push(8'hB0 + 8'(i), i == 4, 2'd2);
    idle();
    chk("R4 first frame", bytes_avail, 8'h03);
    for (int i = 0; i < 3; i++) pop();
    chk("R7 abort status", pkt_status, 1);
    idle();
    chk("R4 second frame", bytes_avail, 8'h05);
    clear_done();
    for (int i = 0; i < 5; i++) begin
      pop();
      chk("R2 second data", host_byte, 8'hB0 + i);
    end
    chk("R7 crc status", pkt_status, 2);
    clear_done();

    // Opening part, continuation, then tail
    for (int i = 0; i < 10; i++) push(8'(i), 1'b0, 2'd0);
    idle();
    chk("R5 opening", bytes_avail, 8'h8A);
    for (int i = 0; i < 4; i++) pop();
    idle();
    chk("R5 continuation", bytes_avail, 8'h86);
    push(8'h10, 1'b0, 2'd0);
    push(8'h11, 1'b1, 2'd0);
    idle();
    chk("R4 tail", bytes_avail, 8'h08);
    for (int i = 0; i < 8; i++) pop();
    chk("R2 tail byte", host_byte, 8'h11);
    chk("R7 good status", pkt_status, 0);
    clear_done();

    // Full buffer and overrun
    for (int i = 0; i < 64; i++) push(pat(99, i), 1'b0, 2'd0);
    idle();
    chk("R10 full unmarked", bytes_avail, 8'hC0);
    chk("R3 no overrun yet", overrun, 0);
    push(8'hEE, 1'b1, 2'd2);
    chk("R3 overrun set", overrun, 1);
    idle();
    chk("R3 count kept", bytes_avail, 8'hC0);
    // full with simultaneous read: write still dropped
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'hEF; in_last = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; host_rd = 1'b0;
    chk("R3 drop with read", host_byte, pat(99, 0));
    idle();
    chk("R3 count after read", bytes_avail, 8'hBF);
    idle(); idle();
    chk("R9 overrun held", overrun, 1);
    @(negedge clk); clr_overrun = 1'b1;
    @(negedge clk); clr_overrun = 1'b0;
    chk("R9 overrun cleared", overrun, 0);
    for (int i = 1; i < 64; i++) begin
      pop();
      chk("R3 contents kept", host_byte, pat(99, i));
    end
    chk("R7 unmarked no done", pkt_done, 0);

    // Read on empty is ignored
    pop();
    chk("R8 byte held", host_byte, pat(99, 63));
    chk("R8 done held", pkt_done, 0);
    idle();
    chk("R8 avail", bytes_avail, 8'h80);

    // Set wins over clear in the same cycle
    push(8'h77, 1'b1, 2'd1);
    idle();
    @(negedge clk);
    host_rd = 1'b1; clr_pkt_done = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; clr_pkt_done = 1'b0;
    chk("R9 set beats clear", pkt_done, 1);
    chk("R7 status on collide", pkt_status, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule